// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit with Register Stack Cache

This unit executes an already-decoded instruction stream for a stack machine whose arithmetic names no operands. Each instruction arrives with a valid/ready handshake as an opcode plus one argument. For a memory push or a pop, the argument is a word address. For a literal push, it is the value. An add or a multiply takes both sources from the two topmost stack entries and leaves its single result on top. No operand address is needed.

The top `N` stack entries are held in a small register file. Arithmetic on cached entries therefore never touches memory. When a push would overflow the cache, the bottom cached entry is first written to a spill region in data memory. When a pop or an arithmetic operation needs an entry that has gone to memory, the unit refills it one word at a time. During a spill or a refill the handshake stays stalled. One synchronous single-port memory, with one cycle of read latency, serves both program data and the spill region. A one-cycle completion pulse marks every retired instruction. A sticky flag records any attempt to take more entries than the stack holds.

Top module: `stk_engine`

## Requirements
- R1: After reset, `in_ready` is high and `done`, `err_underflow` and `mem_req` are low.
- R2: Opcode 0 (push) reads the memory word at `in_arg` and places it on top of the stack. Opcode 1 (push literal) places `in_arg` itself on top and makes no memory access unless a spill is required.
- R3: Opcode 2 (pop) writes the top entry to memory address `in_arg` and removes it from the stack.
- R4: Opcode 3 (add) and opcode 4 (multiply) remove the two topmost entries and push one result. Both operate on 16-bit two's complement values with wrap-around, and the multiply keeps the low 16 bits of the product.
- R5: An add or multiply whose two operands are both cached makes no memory request.
- R6: A push issued while `N` entries are cached first writes the bottom cached entry to address `SPILL_BASE + k`, where `k` is the number of entries already spilled. Spill-region writes happen only while the cache is full.
- R7: Entries that were spilled are refilled on demand, so values always come back in last-in first-out order at any depth. The handshake does not accept and memory traffic happens only while an instruction is in progress.
- R8: A pop on an empty stack, or an add or multiply with fewer than two entries, sets `err_underflow`. The flag stays set until reset. The stack is left unchanged and no memory write is made.
- R9: `done` is high for exactly one cycle for each instruction, including one rejected for underflow. No new instruction is accepted in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_op | input | 3 | Opcode: 0 push, 1 push literal, 2 pop, 3 add, 4 multiply |
| in_arg | input | W | Memory address (push, pop) or literal value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle pulse per retired instruction |
| err_underflow | output | 1 | Sticky stack underflow flag |

## Verification
The assertions check several properties on every cycle. They check that the completion pulse lasts a single cycle, that the unit is not ready right after an acceptance, and that no memory request is made while the unit is idle. They also check that the underflow flag never clears and that spill-region writes occur only with a full cache. Only the bench's scenarios can show the values themselves. These are the results of the expression sweep, the wrap-around of add and multiply, and the exact spill addresses and contents. They also include last-in first-out order across every depth up to twice the cache size, the absence of memory traffic for cached arithmetic and literal pushes, and the stack being preserved after rejected instructions.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH    = 3'd0,
    OP_PUSHLIT = 3'd1,
    OP_POP     = 3'd2,
    OP_ADD     = 3'd3,
    OP_MUL     = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_SPILL, S_LOAD, S_LOADW, S_FILL, S_FILLW
  } st_e;

  typedef enum logic [1:0] {
    CC_HOLD, CC_SHDN, CC_SHUP, CC_WR
  } ccmd_e;
endpackage

// File: rtl/stk_cache.sv
module stk_cache
  import stk_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  ccmd_e               cmd,
  input  logic [IW-1:0]       idx,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] ent
);
  logic [N-1:0][W-1:0] ent_d;
  logic                ent_en;

  always_comb begin
    ent_d  = ent;
    ent_en = (cmd != CC_HOLD);
    case (cmd)
      CC_SHDN: for (int i = 0; i < N - 1; i++) ent_d[i] = ent[i+1];
      CC_SHUP: begin
        for (int i = N - 1; i > 0; i--) ent_d[i] = ent[i-1];
        ent_d[0] = din;
      end
      CC_WR:   ent_d[idx] = din;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent <= ent_d;
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic         is_mul,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] sum, prod;
  assign sum  = a + b;
  assign prod = a * b;
  assign y    = is_mul ? prod : sum;
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int             W          = 16,
  parameter int             N          = 4,
  parameter int             AW         = 8,
  parameter logic [AW-1:0]  SPILL_BASE = AW'(128)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [W-1:0]  in_arg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          done,
  output logic          err_underflow
);
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  st_e           st_q, st_d;
  op_e           op_q;
  logic [W-1:0]  arg_q;
  logic          lat;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] sp_q, sp_d;
  logic          err_q, err_d, done_q, done_d;
  logic [AW:0]   dep;
  logic [IW-1:0] top_idx, sec_idx, cidx;
  ccmd_e         cmd;
  logic [W-1:0]  cdin, alu_y;
  logic [N-1:0][W-1:0] ent;

  assign dep     = (AW+1)'(cnt_q) + (AW+1)'(sp_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign sec_idx = IW'(cnt_q - CW'(2));

  stk_cache #(.W(W), .N(N), .IW(IW)) u_cache (
    .clk(clk), .cmd(cmd), .idx(cidx), .din(cdin), .ent(ent)
  );

  stk_alu #(.W(W)) u_alu (
    .is_mul(op_q == OP_MUL), .a(ent[sec_idx]), .b(ent[top_idx]), .y(alu_y)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sp_d      = sp_q;
    err_d     = err_q;
    done_d    = 1'b0;
    lat       = 1'b0;
    cmd       = CC_HOLD;
    cidx      = top_idx;
    cdin      = arg_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = arg_q[AW-1:0];
    mem_wdata = ent[top_idx];
    case (st_q)
      S_IDLE: if (in_valid) begin
        lat  = 1'b1;
        st_d = S_DISP;
      end
      S_DISP: begin
        case (op_q)
          OP_PUSH, OP_PUSHLIT: begin
            if (cnt_q == CW'(N)) st_d = S_SPILL;
            else if (op_q == OP_PUSH) st_d = S_LOAD;
            else begin
              cmd    = CC_WR;
              cidx   = IW'(cnt_q);
              cnt_d  = cnt_q + CW'(1);
              done_d = 1'b1;
              st_d   = S_IDLE;
            end
          end
          OP_POP: begin
            if (dep == '0) begin
              err_d  = 1'b1;
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else if (cnt_q == '0) st_d = S_FILL;
            else begin
              mem_req = 1'b1;
              mem_we  = 1'b1;
              cnt_d   = cnt_q - CW'(1);
              done_d  = 1'b1;
              st_d    = S_IDLE;
            end
          end
          OP_ADD, OP_MUL: begin
            if (dep < (AW+1)'(2)) begin
              err_d  = 1'b1;
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else if (cnt_q < CW'(2)) st_d = S_FILL;
            else begin
              cmd    = CC_WR;
              cidx   = sec_idx;
              cdin   = alu_y;
              cnt_d  = cnt_q - CW'(1);
              done_d = 1'b1;
              st_d   = S_IDLE;
            end
          end
          default: begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end
        endcase
      end
      S_SPILL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = SPILL_BASE + sp_q;
        mem_wdata = ent[0];
        cmd       = CC_SHDN;
        cnt_d     = cnt_q - CW'(1);
        sp_d      = sp_q + AW'(1);
        st_d      = S_DISP;
      end
      S_LOAD: begin
        mem_req = 1'b1;
        st_d    = S_LOADW;
      end
      S_LOADW: begin
        cmd    = CC_WR;
        cidx   = IW'(cnt_q);
        cdin   = mem_rdata;
        cnt_d  = cnt_q + CW'(1);
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = SPILL_BASE + sp_q - AW'(1);
        st_d     = S_FILLW;
      end
      S_FILLW: begin
        cmd   = CC_SHUP;
        cdin  = mem_rdata;
        cnt_d = cnt_q + CW'(1);
        sp_d  = sp_q - AW'(1);
        st_d  = S_DISP;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sp_q   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sp_q   <= sp_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat) begin
      op_q  <= op_e'(in_op);
      arg_q <= in_arg;
    end
  end

  assign in_ready      = (st_q == S_IDLE);
  assign done          = done_q;
  assign err_underflow = err_q;
endmodule

module stk_engine_chk #(
  parameter int            N          = 4,
  parameter int            AW         = 8,
  parameter logic [AW-1:0] SPILL_BASE = AW'(128),
  parameter int            CW         = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          err_underflow,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] cnt
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
  // R6
  spill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr >= SPILL_BASE) |-> cnt == CW'(N));
endmodule

bind stk_engine stk_engine_chk #(.N(N), .AW(AW), .SPILL_BASE(SPILL_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .err_underflow(err_underflow), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .cnt(cnt_q)
);

// File: tb/stk_engine_test.sv
module stk_engine_test;
  localparam int N    = 4;
  localparam int BASE = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [15:0] in_arg = 16'd0;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'd0;
  logic        done, err_underflow;

  logic [15:0] mem [0:255];
  int nchk = 0, errs = 0, nreq = 0, cyc = 0;

  always #5 clk = ~clk;

  stk_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_arg(in_arg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err_underflow(err_underflow)
  );

  always @(posedge clk) begin
    cyc++;
    if (mem_req) begin
      nreq++;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic exec(input logic [2:0] op, input logic [15:0] arg);
    int wd;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_arg = arg;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wd = 0;
    while (!done && wd < 100) begin @(negedge clk); wd++; end
    if (!done) check("R9 done timeout", 16'd0, 16'd1);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [15:0] av [6] = '{16'd0, 16'd1, 16'd7, 16'd300, 16'hFFFF, 16'h1234};
    logic [15:0] bv [4] = '{16'd0, 16'd5, 16'hFF6F, 16'd1000};
    int r0;
    do_reset();
    // R1 reset state
    check("R1 in_ready", {15'd0, in_ready}, 16'd1);
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 err", {15'd0, err_underflow}, 16'd0);
    check("R1 mem_req", {15'd0, mem_req}, 16'd0);

    // R2 R3 R4: a*(145+b) sweep
    foreach (av[i]) foreach (bv[j]) begin
      mem[10] = av[i]; mem[11] = bv[j]; mem[12] = 16'hDEAD;
      exec(3'd0, 16'd10);
      exec(3'd1, 16'd145);
      exec(3'd0, 16'd11);
      exec(3'd3, 16'd0);
      exec(3'd4, 16'd0);
      exec(3'd2, 16'd12);
      @(negedge clk);
      check("R2 R3 R4 expression", mem[12], 16'(av[i] * (16'd145 + bv[j])));
    end

    // R4 wrap-around of multiply and add
    exec(3'd1, 16'h1234); exec(3'd1, 16'h5678); exec(3'd4, 16'd0); exec(3'd2, 16'd20);
    @(negedge clk);
    check("R4 mult low bits", mem[20], 16'(32'h1234 * 32'h5678));
    exec(3'd1, 16'hFFFF); exec(3'd1, 16'd2); exec(3'd3, 16'd0); exec(3'd2, 16'd21);
    @(negedge clk);
    check("R4 add wrap", mem[21], 16'd1);

    // R2 literal push makes no access; R5 cached arithmetic makes no access
    r0 = nreq;
    exec(3'd1, 16'd9); exec(3'd1, 16'd4);
    check("R2 pushlit no memory", 16'(nreq - r0), 16'd0);
    r0 = nreq;
    exec(3'd4, 16'd0);
    check("R5 cached mult no memory", 16'(nreq - r0), 16'd0);
    exec(3'd2, 16'd22);
    @(negedge clk);
    check("R3 pop value", mem[22], 16'd36);
    // R9 single-cycle pulse, ready again
    check("R9 done pulse", {15'd0, done}, 16'd0);
    check("R9 ready after", {15'd0, in_ready}, 16'd1);

    // R6 spill contents and addresses, R7 LIFO refill, depths 1..2N+2
    for (int k = 1; k <= 2 * N + 2; k++) begin
      for (int i = 0; i < k; i++) exec(3'd1, 16'(100 * k + i));
      @(negedge clk);
      for (int j = 0; j < k - N; j++)
        check("R6 spill slot", mem[BASE + j], 16'(100 * k + j));
      for (int i = 0; i < k; i++) exec(3'd2, 16'(40 + i));
      @(negedge clk);
      for (int i = 0; i < k; i++)
        check("R7 LIFO order", mem[40 + i], 16'(100 * k + k - 1 - i));
    end

    // R7 deep arithmetic across refills
    for (int i = 1; i <= 10; i++) exec(3'd1, 16'(i));
    for (int i = 0; i < 9; i++) exec(3'd3, 16'd0);
    exec(3'd2, 16'd23);
    @(negedge clk);
    check("R7 deep sum", mem[23], 16'd55);
    check("R8 no error yet", {15'd0, err_underflow}, 16'd0);

    // R8 underflow
    mem[30] = 16'hAAAA;
    exec(3'd2, 16'd30);
    @(negedge clk);
    check("R8 err on empty pop", {15'd0, err_underflow}, 16'd1);
    check("R8 no write on empty pop", mem[30], 16'hAAAA);
    exec(3'd1, 16'h0055);
    exec(3'd3, 16'd0);
    exec(3'd4, 16'd0);
    check("R8 err sticky", {15'd0, err_underflow}, 16'd1);
    exec(3'd2, 16'd31);
    @(negedge clk);
    check("R8 stack unchanged", mem[31], 16'h0055);

    do_reset();
    check("R1 err cleared by reset", {15'd0, err_underflow}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule